// File: doc/BRIEF.md
# Gated Byte-Wide Static Memory Access Port

This block is a clocked model of the access side of a byte-wide static memory with 131,072 locations and a 17-bit address. It samples active-low chip select, write strobe and output enable on every clock. From them it decodes read cycles and write cycles, drives the output-enable of a bidirectional data bus that appears here as separate in, out and enable pins, and commits written bytes to an external storage array. Two further inputs gate all of this. One is an active-low store-busy pin. The other is a transfer-active flag from the nonvolatile store/recall sequencer. While either one blocks, no read or write takes place.

The port does not hold the array itself. It presents a read address straight from the address pins and registers the returned byte one clock later, which stands in for the access time. A completed write produces a single-cycle write strobe with the latched address and the captured byte. It also produces a one-cycle pulse to the store/recall controller, so that controller can skip stores when nothing has changed. Analog timing appears only as the order of events across clock cycles.

Top module: `sram_gate_port`

## Requirements
- R1: If chip select and output enable are low while the write strobe and store-busy are high and no transfer is active at a clock edge, `dq_oe` is 1 after that edge.
- R2: During a read, `dq_out` shows, one clock after the address was sampled, the array byte at that address, and it tracks address changes with no toggle of any control pin.
- R3: `dq_oe` is 0 after any edge at which output enable is high, chip select is high, the write strobe is low or store-busy is low. This includes a write begun while output enable stays low.
- R4: A write cycle runs while chip select and the write strobe are both low, store-busy is high and no transfer is active. When chip select or the write strobe returns high, `arr_we` is 1 for exactly one cycle. At that point `arr_wdata` holds the `dq_in` value sampled at the last edge of the write cycle.
- R5: The committed address is the value on `addr` at the edge where chip select was first seen low, even if `addr` changes later in the cycle.
- R6: While store-busy is low or a transfer is active, no read output is enabled and no write is committed. A write whose end falls together with a block, or that a block interrupts, is dropped, and the array keeps its old byte.
- R7: `wr_seen` pulses for one cycle with every committed write and at no other time.
- R8: During reset `dq_oe`, `arr_we` and `wr_seen` are 0. A write in progress when reset comes is never committed.
- R9: With chip select held low, each separate write strobe pulse commits its own byte to the same latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write strobe, active low |
| oen_n | input | 1 | Output enable, active low |
| busy_n | input | 1 | Store-busy pin, active low, blocks access |
| xfer_active | input | 1 | Bulk store/recall transfer running |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Data bus, inbound side |
| dq_out | output | 8 | Data bus, outbound side |
| dq_oe | output | 1 | Drive enable for the data bus |
| arr_raddr | output | 17 | Read address to the storage array |
| arr_rdata | input | 8 | Byte returned by the storage array |
| arr_we | output | 1 | Write strobe to the storage array |
| arr_waddr | output | 17 | Write address to the storage array |
| arr_wdata | output | 8 | Write byte to the storage array |
| wr_seen | output | 1 | Write-occurred pulse to the store/recall controller |

## Verification
Two things can land on the same clock edge: the end of a write (chip select or strobe rising) and the start of a block by store-busy or a transfer. The bench sets this up by raising chip select and the transfer flag in one vector. In another run it drops store-busy in the middle of a write and only later releases the strobe. Each case passes only if `arr_we` and `wr_seen` stay low and a later read of that address returns the byte the array held before. A second overlap also gets a check. When a write strobe rises while output enable is still low, the edge that commits the write also opens a read of the old byte. The bench checks both outputs from that single edge.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic busy_n;
        logic xfer;
    } ctl_t;

    typedef struct packed {
        logic rd_ok;    // read cycle legal at this edge
        logic wr_ok;    // write cycle legal at this edge
        logic blocked;  // store-busy or transfer gating
        logic cs_fall;  // chip select first seen low
        logic wr_end;   // strobe or select released
    } dec_t;

endpackage

// File: rtl/sgp_decode.sv
module sgp_decode
    import sgp_pkg::*;
(
    input  ctl_t ctl,
    input  logic cs_prev,
    output dec_t dec
);

    always_comb begin
        dec.blocked = !ctl.busy_n || ctl.xfer;
        dec.cs_fall = cs_prev && !ctl.cs_n;
        dec.wr_end  = ctl.cs_n || ctl.we_n;
        dec.wr_ok   = !ctl.cs_n && !ctl.we_n && !dec.blocked;
        dec.rd_ok   = !ctl.cs_n && !ctl.oe_n && ctl.we_n && !dec.blocked;
    end

endmodule

// File: rtl/sgp_wr_track.sv
module sgp_wr_track
    import sgp_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  dec_t          dec,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          cs_prev,
    output logic          cm_we,
    output logic [AW-1:0] cm_addr,
    output logic [DW-1:0] cm_data,
    output logic          seen
);

    typedef struct packed {
        logic          cs_prev;
        logic          act;
        logic [AW-1:0] lat;
        logic [DW-1:0] wd;
        logic          we;
        logic          seen;
        logic [AW-1:0] ca;
        logic [DW-1:0] cd;
    } st_t;

    st_t st_d, st_q;
    logic commit;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_n;
        if (dec.cs_fall) begin
            st_d.lat = addr;
        end
        st_d.act = dec.wr_ok;
        if (dec.wr_ok) begin
            st_d.wd = din;
        end
        commit    = st_q.act && !dec.wr_ok && dec.wr_end && !dec.blocked;
        st_d.we   = commit;
        st_d.seen = commit;
        if (commit) begin
            st_d.ca = st_q.lat;
            st_d.cd = st_q.wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_prev = st_q.cs_prev;
    assign cm_we   = st_q.we;
    assign cm_addr = st_q.ca;
    assign cm_data = st_q.cd;
    assign seen    = st_q.seen;

endmodule

// File: rtl/sgp_rd_path.sv
module sgp_rd_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ok,
    input  logic [DW-1:0] rdata,
    output logic          oe,
    output logic [DW-1:0] dout
);

    typedef struct packed {
        logic          oe;
        logic [DW-1:0] dout;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oe = rd_ok;
        if (rd_ok) begin
            st_d.dout = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe   = st_q.oe;
    assign dout = st_q.dout;

endmodule

// File: rtl/sram_gate_port.sv
module sram_gate_port
    import sgp_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wen_n,
    input  logic          oen_n,
    input  logic          busy_n,
    input  logic          xfer_active,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [AW-1:0] arr_raddr,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output logic          wr_seen
);

    ctl_t ctl;
    dec_t dec;
    logic cs_prev;

    always_comb begin
        ctl.cs_n   = cs_n;
        ctl.we_n   = wen_n;
        ctl.oe_n   = oen_n;
        ctl.busy_n = busy_n;
        ctl.xfer   = xfer_active;
    end

    sgp_decode i_decode (
        .ctl     (ctl),
        .cs_prev (cs_prev),
        .dec     (dec)
    );

    sgp_wr_track #(.AW(AW), .DW(DW)) i_wr_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .dec     (dec),
        .addr    (addr),
        .din     (dq_in),
        .cs_prev (cs_prev),
        .cm_we   (arr_we),
        .cm_addr (arr_waddr),
        .cm_data (arr_wdata),
        .seen    (wr_seen)
    );

    sgp_rd_path #(.DW(DW)) i_rd_path (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_ok (dec.rd_ok),
        .rdata (arr_rdata),
        .oe    (dq_oe),
        .dout  (dq_out)
    );

    assign arr_raddr = addr;

endmodule

// File: rtl/sram_gate_port_chk.sv
module sram_gate_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic wen_n,
    input logic oen_n,
    input logic busy_n,
    input logic xfer_active,
    input logic dq_oe,
    input logic arr_we,
    input logic wr_seen
);

    p_read_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oen_n && wen_n && busy_n && !xfer_active) |=> dq_oe);

    p_drive_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oen_n || !wen_n || !busy_n) |=> !dq_oe);

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);

    p_we_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ($past(cs_n) || $past(wen_n)));

    p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active || !busy_n) |=> (!dq_oe && !arr_we));

    p_seen_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |=> !wr_seen);

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (!arr_we && !wr_seen && !dq_oe);
        end
    end

endmodule

bind sram_gate_port sram_gate_port_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wen_n       (wen_n),
    .oen_n       (oen_n),
    .busy_n      (busy_n),
    .xfer_active (xfer_active),
    .dq_oe       (dq_oe),
    .arr_we      (arr_we),
    .wr_seen     (wr_seen)
);

// File: tb/test_sram_gate_port.sv
module test_sram_gate_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wen_n = 1'b1, oen_n = 1'b1, busy_n = 1'b1, xfer_active = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [16:0] arr_raddr;
    logic [7:0]  arr_rdata;
    logic        arr_we;
    logic [16:0] arr_waddr;
    logic [7:0]  arr_wdata;
    logic        wr_seen;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sram_gate_port i_sram_gate_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wen_n(wen_n), .oen_n(oen_n),
        .busy_n(busy_n), .xfer_active(xfer_active), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .wr_seen(wr_seen)
    );

    // Bench storage: low address byte selects, initial content is index ^ 8'h5A.
    logic [7:0] bmem [256];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) bmem[k] <= 8'(k) ^ 8'h5A;
        end else if (arr_we) begin
            bmem[arr_waddr[7:0]] <= arr_wdata;
        end
    end
    assign arr_rdata = bmem[arr_raddr[7:0]];

    typedef struct packed {
        logic cs, we, oe, bz, xf;
        logic [16:0] a;
        logic [7:0]  d;
        logic        eoe;
        logic [7:0]  erd;
        logic        ewe;
        logic [16:0] ewa;
        logic [7:0]  ewd;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VT [NV] = '{
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00}, // idle
        '{0,1,0,1,0, 17'h00010, 8'h00, 1, 8'h4A, 0, 17'h0, 8'h00}, // R1 read
        '{0,1,0,1,0, 17'h00023, 8'h00, 1, 8'h79, 0, 17'h0, 8'h00}, // R2 address follows
        '{0,1,1,1,0, 17'h00023, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00}, // R3 oe high
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,0,1,1,0, 17'h10030, 8'hC3, 0, 8'h00, 0, 17'h0, 8'h00}, // write starts at cs fall
        '{0,0,1,1,0, 17'h00099, 8'hC4, 0, 8'h00, 0, 17'h0, 8'h00}, // R5 addr moves
        '{1,0,1,1,0, 17'h00099, 8'h00, 0, 8'h00, 1, 17'h10030, 8'hC4}, // R4 cs-ended
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,1,0,1,0, 17'h10030, 8'h00, 1, 8'hC4, 0, 17'h0, 8'h00},
        '{0,0,0,1,0, 17'h00041, 8'h11, 0, 8'h00, 0, 17'h0, 8'h00}, // R3 oe low, we falls
        '{0,0,0,1,0, 17'h10030, 8'h22, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,1,0,1,0, 17'h10030, 8'h00, 1, 8'hC4, 1, 17'h10030, 8'h22}, // R4 we-ended + read
        '{0,0,1,1,0, 17'h00077, 8'h33, 0, 8'h00, 0, 17'h0, 8'h00}, // R9 second pulse
        '{0,1,1,1,0, 17'h00077, 8'h00, 0, 8'h00, 1, 17'h10030, 8'h33}, // R9 commit
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,0,1,0,0, 17'h00050, 8'h55, 0, 8'h00, 0, 17'h0, 8'h00}, // R6 busy write
        '{1,1,1,1,0, 17'h00050, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,1,0,1,1, 17'h00050, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00}, // R6 read during xfer
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,0,1,1,0, 17'h00060, 8'h66, 0, 8'h00, 0, 17'h0, 8'h00},
        '{1,1,1,1,1, 17'h00060, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00}, // R6 end meets xfer
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,1,0,1,0, 17'h00060, 8'h00, 1, 8'h3A, 0, 17'h0, 8'h00}, // R6 old byte kept
        '{0,1,0,1,0, 17'h10030, 8'h00, 1, 8'h33, 0, 17'h0, 8'h00}, // R9 last byte stored
        '{0,1,0,0,0, 17'h10030, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00}, // R3 busy during read
        '{1,1,1,1,0, 17'h00000, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,0,1,1,0, 17'h00070, 8'h77, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,0,1,0,0, 17'h00070, 8'h77, 0, 8'h00, 0, 17'h0, 8'h00}, // R6 busy mid-write
        '{1,1,1,1,0, 17'h00070, 8'h00, 0, 8'h00, 0, 17'h0, 8'h00},
        '{0,1,0,1,0, 17'h00070, 8'h00, 1, 8'h2A, 0, 17'h0, 8'h00}  // R6 old byte kept
    };

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cs_n = v.cs; wen_n = v.we; oen_n = v.oe; busy_n = v.bz; xfer_active = v.xf;
        addr = v.a; dq_in = v.d;
    endtask

    task automatic check_vec(input int i);
        vec_t v;
        v = VT[i];
        chk(dq_oe == v.eoe, $sformatf("R1 R3 R6 dq_oe vec %0d", i), 32'(dq_oe), 32'(v.eoe));
        if (v.eoe) chk(dq_out == v.erd, $sformatf("R2 dq_out vec %0d", i), 32'(dq_out), 32'(v.erd));
        chk(arr_we == v.ewe, $sformatf("R4 R6 arr_we vec %0d", i), 32'(arr_we), 32'(v.ewe));
        chk(wr_seen == v.ewe, $sformatf("R7 wr_seen vec %0d", i), 32'(wr_seen), 32'(v.ewe));
        if (v.ewe) begin
            chk(arr_waddr == v.ewa, $sformatf("R5 arr_waddr vec %0d", i), 32'(arr_waddr), 32'(v.ewa));
            chk(arr_wdata == v.ewd, $sformatf("R4 arr_wdata vec %0d", i), 32'(arr_wdata), 32'(v.ewd));
        end
    endtask

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!dq_oe && !arr_we && !wr_seen, "R8 outputs in reset", {dq_oe, arr_we, wr_seen}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        apply(VT[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check_vec(i);
            if (i + 1 < NV) apply(VT[i + 1]);
        end

        // R8 pending write discarded by reset
        apply(VT[0]);
        @(negedge clk);
        cs_n = 1'b0; wen_n = 1'b0; addr = 17'h00080; dq_in = 8'h88;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!dq_oe && !arr_we && !wr_seen, "R8 outputs during mid-write reset", {dq_oe, arr_we, wr_seen}, 32'h0);
        cs_n = 1'b1; wen_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(!arr_we && !wr_seen, "R8 no commit after reset", {arr_we, wr_seen}, 32'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule